// File: doc/BRIEF.md
# Memory Area Chip-Select and Wait-State Controller

This block sits between a CPU's physical address bus and a set of external static memories. It looks at a three-bit field of the 32-bit physical address and picks one of three external areas. The area codes are 3, 4 and 5. It raises that area's chip-select and a read strobe or per-byte write strobes. It holds them for a number of cycles set by a per-area wait field, then answers the CPU. The top three address bits take no part in the decode, so every upper-bit value aliases the same area.

Each area also has a port-width field. An access wider than the port, or misaligned for its size, is refused with an error. So is an access to an address outside the three areas. Area 5 can be put in card mode. Its lower half is then a memory-card space and its upper half an I/O-card space, and a separate output marks the I/O half.

The CPU side is a valid/ready pair.
- The CPU raises `req_valid` with its address, direction and size, and holds them stable until `req_ready` is seen high.
- `req_ready` is a one-cycle pulse, and the transfer completes in that cycle.
- The controller applies back-pressure only through wait cycles.
- `req_valid` is ignored in the ready cycle, so a following request may be presented straight away and is accepted on the next edge.
- Configuration inputs are sampled only at acceptance.

Top module: `mem_area_csctl`

## Requirements
- R1: Address bits 28:26 select the area: 011 raises `cs_a3`, 100 raises `cs_a4`, 101 raises `cs_a5`. Bits 31:29 have no effect on the decode, and at most one select is high at any time.
- R2: A valid request seen in the idle state on a rising edge is accepted. From the next cycle its select and strobe are high for W+2 cycles, where W is the area's wait count. `req_ready` is high in the last of these cycles only. On the following edge all selects and strobes go low.
- R3: Area 3 inserts W = `cfg_wait3` wait cycles (0 to 3).
- R4: Areas 4 and 5 take their wait count from a 3-bit code (`cfg_wait4`, `cfg_wait5`) mapped as 0→0, 1→1, 2→2, 3→3, 4→4, 5→6, 6→8, 7→10.
- R5: A read (`req_write`=0) raises `rd_oe` and no write lane. A write raises write lanes and not `rd_oe`.
- R6: Access size `req_size` is encoded 00 byte, 01 word, 10 longword. A byte write raises lane `req_addr[1:0]`. A word write raises lanes 1:0 (`req_addr[1]`=0) or 3:2 (`req_addr[1]`=1). A longword write raises all four lanes. `wr_lane[0]` is the least-significant byte lane.
- R7: A word at an odd address, a longword whose `req_addr[1:0]` is not 00, and size code 11 are errors. For an error, `req_ready` and `req_err` are high together in the cycle after acceptance, and no select or strobe is raised.
- R8: Port width fields use 00 byte, 01 word, 10 longword, 11 reserved. An access larger than the selected area's port, or to an area whose width code is 11, is an error handled as in R7.
- R9: An address whose bits 28:26 are not 011, 100 or 101 raises no select and is handled as an error, as in R7.
- R10: `card_io` is high with `cs_a5` exactly when `cfg_card_en`=1 and `req_addr[25]`=1 for an area-5 access. It is low for every other access.
- R11: `req_ready` is a single-cycle pulse. `req_valid` is ignored in the ready cycle, and a request held high across it is accepted on the following edge.
- R12: During reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request valid |
| req_addr | input | 32 | CPU physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Error flag, valid with `req_ready` |
| cfg_wait3 | input | 2 | Area 3 wait count |
| cfg_wait4 | input | 3 | Area 4 wait code |
| cfg_wait5 | input | 3 | Area 5 wait code |
| cfg_width3 | input | 2 | Area 3 port width |
| cfg_width4 | input | 2 | Area 4 port width |
| cfg_width5 | input | 2 | Area 5 port width |
| cfg_card_en | input | 1 | Area 5 card mode enable |
| cs_a3 | output | 1 | Area 3 chip-select, active high |
| cs_a4 | output | 1 | Area 4 chip-select, active high |
| cs_a5 | output | 1 | Area 5 chip-select, active high |
| rd_oe | output | 1 | Read strobe, usable as output enable |
| wr_lane | output | 4 | Per-byte write strobes, bit 0 = lowest byte |
| card_io | output | 1 | Area 5 access falls in the I/O-card half |

## Verification
A wrong wait-counter load or decrement first shows as `req_ready` arriving early or late on the first access to the affected area. The select then stays high for the wrong number of cycles, which is visible within at most twelve cycles of acceptance. A wrong latched area or lane pattern shows on `cs_a*`, `wr_lane` or `card_io` in the first cycle after acceptance. An FSM that fails to return to idle shows as selects held past the ready pulse, or as the next request never being answered.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } ctl_state_e;

  localparam int WAIT_CNT_W = 4;
  localparam int BUS_LANES  = 4;

  // Expand a 3-bit long-range wait code: linear to 4, then steps of two.
  function automatic logic [WAIT_CNT_W-1:0] long_wait_code(input logic [2:0] code);
    logic [WAIT_CNT_W-1:0] r;
    case (code)
      3'd5:    r = 4'd6;
      3'd6:    r = 4'd8;
      3'd7:    r = 4'd10;
      default: r = {1'b0, code};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acs_area_decode.sv
`timescale 1ns/1ps
module acs_area_decode #(
  parameter int SEL_W      = 3,
  parameter int FIRST_AREA = 3,
  parameter int NUM_AREAS  = 3
) (
  input  logic [SEL_W-1:0]     sel_field,
  output logic [NUM_AREAS-1:0] hit
);

  // One comparator per supported area; codes are consecutive from FIRST_AREA.
  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    localparam logic [SEL_W-1:0] CODE = SEL_W'(FIRST_AREA + i);
    assign hit[i] = (sel_field == CODE);
  end

endmodule

// File: rtl/acs_lane_gen.sv
`timescale 1ns/1ps
module acs_lane_gen
  import acs_pkg::*;
#(
  parameter int LANES = BUS_LANES,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] offs,
  input  logic [1:0]       port_w,
  output logic [LANES-1:0] lanes,
  output logic             fault
);

  logic [LANES-1:0] raw;
  logic             align_bad;
  logic             width_bad;

  always_comb begin
    raw       = '0;
    align_bad = 1'b0;
    unique case (size)
      SZ_BYTE: raw = LANES'(1) << offs;
      SZ_WORD: begin
        align_bad = offs[0];
        raw       = offs[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      end
      SZ_LONG: begin
        align_bad = |offs;
        raw       = '1;
      end
      default: align_bad = 1'b1;
    endcase
  end

  // Port narrower than the access, or a reserved width code, refuses it.
  assign width_bad = (port_w == SZ_RSVD) || (size > port_w);
  assign fault     = align_bad || width_bad;
  assign lanes     = fault ? '0 : raw;

endmodule

// File: rtl/acs_wait_ctr.sv
`timescale 1ns/1ps
module acs_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (step && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/mem_area_csctl.sv
`timescale 1ns/1ps
module mem_area_csctl
  import acs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_LO     = 26,
  parameter int SEL_W      = 3,
  parameter int CARD_BIT   = 25,
  parameter int FIRST_AREA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  output logic              req_ready,
  output logic              req_err,
  input  logic [1:0]        cfg_wait3,
  input  logic [2:0]        cfg_wait4,
  input  logic [2:0]        cfg_wait5,
  input  logic [1:0]        cfg_width3,
  input  logic [1:0]        cfg_width4,
  input  logic [1:0]        cfg_width5,
  input  logic              cfg_card_en,
  output logic              cs_a3,
  output logic              cs_a4,
  output logic              cs_a5,
  output logic              rd_oe,
  output logic [3:0]        wr_lane,
  output logic              card_io
);

  localparam int NUM_AREAS = 3;
  localparam int CARD_IDX  = 2;
  localparam int SEL_HI    = SEL_LO + SEL_W - 1;
  localparam int OFF_W     = $clog2(BUS_LANES);

  // Address bits outside the area field, card bit and byte offset.
  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[ADDR_W-1:SEL_HI+1], req_addr[CARD_BIT-1:OFF_W]};

  // ---------------- decode ----------------
  logic [NUM_AREAS-1:0] hit;

  acs_area_decode #(
    .SEL_W     (SEL_W),
    .FIRST_AREA(FIRST_AREA),
    .NUM_AREAS (NUM_AREAS)
  ) u_dec (
    .sel_field(req_addr[SEL_HI:SEL_LO]),
    .hit      (hit)
  );

  // ---------------- per-area configuration ----------------
  logic [1:0]            port_w [NUM_AREAS];
  logic [WAIT_CNT_W-1:0] wait_n [NUM_AREAS];

  assign port_w[0] = cfg_width3;
  assign port_w[1] = cfg_width4;
  assign port_w[2] = cfg_width5;
  assign wait_n[0] = {2'b00, cfg_wait3};
  assign wait_n[1] = long_wait_code(cfg_wait4);
  assign wait_n[2] = long_wait_code(cfg_wait5);

  logic [1:0]            sel_port_w;
  logic [WAIT_CNT_W-1:0] sel_wait;

  always_comb begin
    sel_port_w = SZ_RSVD;
    sel_wait   = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (hit[i]) begin
        sel_port_w = port_w[i];
        sel_wait   = wait_n[i];
      end
    end
  end

  // ---------------- byte lanes ----------------
  logic [BUS_LANES-1:0] lanes;
  logic                 lane_fault;

  acs_lane_gen #(.LANES(BUS_LANES)) u_lane (
    .size  (req_size),
    .offs  (req_addr[OFF_W-1:0]),
    .port_w(sel_port_w),
    .lanes (lanes),
    .fault (lane_fault)
  );

  // ---------------- control ----------------
  ctl_state_e           state;
  logic                 bad;
  logic                 take;
  logic                 wait_zero;
  logic [NUM_AREAS-1:0] cs_q;
  logic                 rd_q;
  logic [BUS_LANES-1:0] we_q;
  logic                 card_q;
  logic                 rdy_q;
  logic                 err_q;

  assign bad  = lane_fault || (hit == '0);
  assign take = (state == ST_IDLE) && req_valid;

  acs_wait_ctr #(.CNT_W(WAIT_CNT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take && !bad),
    .load_val(sel_wait),
    .step    (state == ST_ACCESS),
    .zero    (wait_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cs_q   <= '0;
      rd_q   <= 1'b0;
      we_q   <= '0;
      card_q <= 1'b0;
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (bad) begin
              state <= ST_DONE;
              rdy_q <= 1'b1;
              err_q <= 1'b1;
            end else begin
              state  <= ST_ACCESS;
              cs_q   <= hit;
              rd_q   <= !req_write;
              we_q   <= req_write ? lanes : '0;
              card_q <= hit[CARD_IDX] & cfg_card_en & req_addr[CARD_BIT];
            end
          end
        end
        ST_ACCESS: begin
          if (wait_zero) begin
            state <= ST_DONE;
            rdy_q <= 1'b1;
          end
        end
        ST_DONE: begin
          state  <= ST_IDLE;
          cs_q   <= '0;
          rd_q   <= 1'b0;
          we_q   <= '0;
          card_q <= 1'b0;
          rdy_q  <= 1'b0;
          err_q  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_a3     = cs_q[0];
  assign cs_a4     = cs_q[1];
  assign cs_a5     = cs_q[CARD_IDX];
  assign rd_oe     = rd_q;
  assign wr_lane   = we_q;
  assign card_io   = card_q;
  assign req_ready = rdy_q;
  assign req_err   = err_q;

endmodule

// File: rtl/acs_csctl_checker.sv
`timescale 1ns/1ps
module acs_csctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       req_err,
  input logic       cs_a3,
  input logic       cs_a4,
  input logic       cs_a5,
  input logic       rd_oe,
  input logic [3:0] wr_lane,
  input logic       card_io
);

  logic [2:0] cs;
  logic [4:0] run_len;

  assign cs = {cs_a5, cs_a4, cs_a3};

  // Cycles the current select has been high before the ready cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (req_ready) run_len <= '0;
    else if (|cs)       run_len <= run_len + 1'b1;
  end

  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  p_release_after_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (cs == 3'b000 && !rd_oe && wr_lane == 4'b0000));

  p_select_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs && !req_ready) |=> $stable(cs));

  p_min_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs && req_ready) |-> run_len >= 5'd1);

  p_a3_max_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a3 && req_ready) |-> run_len <= 5'd4);

  p_long_max_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_a4 || cs_a5) && req_ready) |-> run_len <= 5'd11);

  p_rd_wr_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && |wr_lane));

  p_strobe_needs_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe || |wr_lane) |-> |cs);

  p_lane_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lane) |-> (wr_lane inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                    4'b0011, 4'b1100, 4'b1111}));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (cs == 3'b000 && !rd_oe && wr_lane == 4'b0000));

  p_err_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_ready);

  p_card_in_area5_r10: assert property (@(posedge clk) disable iff (!rst_n)
    card_io |-> cs_a5);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

endmodule

bind mem_area_csctl acs_csctl_checker u_chk (.*);

// File: tb/sim_mem_area_csctl.sv
`timescale 1ns/1ps
module sim_mem_area_csctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic [1:0]  req_size;
  logic        req_ready, req_err;
  logic [1:0]  cfg_wait3;
  logic [2:0]  cfg_wait4, cfg_wait5;
  logic [1:0]  cfg_width3, cfg_width4, cfg_width5;
  logic        cfg_card_en;
  logic        cs_a3, cs_a4, cs_a5, rd_oe, card_io;
  logic [3:0]  wr_lane;

  int checks = 0;
  int bad_n  = 0;
  bit hot    = 0;

  always #5 clk = ~clk;

  mem_area_csctl u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference rules ----------------
  function automatic int area_of(input logic [31:0] a);
    return int'(a[28:26]);
  endfunction

  function automatic int ref_wait(input int ar);
    int code;
    if (ar == 3) return int'(cfg_wait3);
    code = (ar == 4) ? int'(cfg_wait4) : int'(cfg_wait5);
    return (code <= 4) ? code : 2 * code - 4;
  endfunction

  function automatic bit ref_bad(input logic [31:0] a, input logic [1:0] sz);
    int ar, pw, nb;
    ar = area_of(a);
    if (ar < 3 || ar > 5) return 1;
    if (sz == 2'd3) return 1;
    pw = (ar == 3) ? int'(cfg_width3) : (ar == 4) ? int'(cfg_width4) : int'(cfg_width5);
    if (pw == 3 || int'(sz) > pw) return 1;
    nb = 1 << sz;
    return (int'(a[1:0]) % nb) != 0;
  endfunction

  function automatic logic [3:0] ref_lanes(input logic [31:0] a, input logic [1:0] sz);
    int nb;
    nb = 1 << sz;
    return 4'(((1 << nb) - 1) << a[1:0]);
  endfunction

  // ---------------- cycle model ----------------
  int         m_left;
  logic [2:0] m_cs;
  logic       m_rd, m_card, m_err;
  logic [3:0] m_we;

  always @(posedge clk) begin
    int ar;
    if (!rst_n) begin
      m_left = 0; m_cs = 0; m_rd = 0; m_we = 0; m_card = 0; m_err = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        m_cs = 0; m_rd = 0; m_we = 0; m_card = 0; m_err = 0;
      end
    end else if (req_valid) begin
      if (ref_bad(req_addr, req_size)) begin
        m_left = 1; m_err = 1;
      end else begin
        ar     = area_of(req_addr);
        m_left = ref_wait(ar) + 2;
        m_cs   = 3'(1 << (ar - 3));
        m_rd   = !req_write;
        m_we   = req_write ? ref_lanes(req_addr, req_size) : 4'b0000;
        m_card = (ar == 5) && cfg_card_en && req_addr[25];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(req_ready === (m_left == 1), "R2", "ready", int'(req_ready), int'(m_left == 1));
      chk(req_err === (m_err && m_left == 1), "R7", "error", int'(req_err), int'(m_err));
      chk({cs_a5, cs_a4, cs_a3} === m_cs, "R1", "selects", int'({cs_a5, cs_a4, cs_a3}), int'(m_cs));
      chk(rd_oe === m_rd, "R5", "read strobe", int'(rd_oe), int'(m_rd));
      chk(wr_lane === m_we, "R6", "write lanes", int'(wr_lane), int'(m_we));
      chk(card_io === m_card, "R10", "card io flag", int'(card_io), int'(m_card));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk(input int up, input int ar, input int low);
    return {3'(up), 3'(ar), 26'(low)};
  endfunction

  task automatic run(input logic [31:0] a, input logic w, input logic [1:0] sz,
                     input string tag, input bit hold_after);
    int  k, csn, exp_len;
    bit  b;
    logic e;
    k = 0; csn = 0;
    req_addr = a; req_write = w; req_size = sz; req_valid = 1'b1;
    b       = ref_bad(a, sz);
    exp_len = b ? 1 : ref_wait(area_of(a)) + 2;
    forever begin
      @(negedge clk);
      k++;
      if (cs_a3 || cs_a4 || cs_a5) csn++;
      if (req_ready === 1'b1 || k > 40) break;
    end
    e = req_err;
    chk(k == exp_len + (hot ? 1 : 0), tag, "ready latency", k, exp_len + (hot ? 1 : 0));
    chk(csn == (b ? 0 : exp_len), tag, "select cycles", csn, b ? 0 : exp_len);
    chk(e === b, tag, "error flag", int'(e), int'(b));
    hot = hold_after;
    if (!hold_after) begin
      req_valid = 1'b0;
      @(negedge clk);
      hot = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog: got 0 expected 1 completion");
    $display("test done: total=%0d bad=%0d", checks, bad_n);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_write = 0; req_size = 0;
    cfg_wait3 = 0; cfg_wait4 = 0; cfg_wait5 = 0;
    cfg_width3 = 2; cfg_width4 = 2; cfg_width5 = 2; cfg_card_en = 0;
    repeat (3) @(negedge clk);
    chk({req_ready, req_err, cs_a3, cs_a4, cs_a5, rd_oe, wr_lane, card_io} === 11'd0,
        "R12", "outputs in reset",
        int'({req_ready, req_err, cs_a3, cs_a4, cs_a5, rd_oe, wr_lane, card_io}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 with R1 shadow aliasing: every wait count, several upper-bit values
    for (int w = 0; w < 4; w++) begin
      cfg_wait3 = 2'(w);
      run(mk(0, 3, 'h100), 0, 2, "R3", 0);
      run(mk(5, 3, 'h3ff0), 1, 2, "R1", 0);
      run(mk(7, 3, 'h8), 0, 2, "R1", 0);
    end

    // R4 wait code mapping, areas 4 and 5
    for (int c = 0; c < 8; c++) begin
      cfg_wait4 = 3'(c);
      cfg_wait5 = 3'(7 - c);
      run(mk(c, 4, 'h40), 1, 2, "R4", 0);
      run(mk(c, 5, 'h80), 0, 2, "R4", 0);
    end

    // R2 basic timing at zero and mid waits
    cfg_wait3 = 0;
    run(mk(1, 3, 0), 0, 0, "R2", 0);
    cfg_wait4 = 3'd6;
    run(mk(2, 4, 4), 1, 1, "R2", 0);

    // R6 byte lanes and R5 direction
    cfg_wait3 = 1;
    for (int o = 0; o < 4; o++) run(mk(0, 3, 'h20 + o), 1, 0, "R6", 0);
    run(mk(0, 3, 'h20), 1, 1, "R6", 0);
    run(mk(0, 3, 'h22), 1, 1, "R6", 0);
    run(mk(0, 3, 'h20), 1, 2, "R6", 0);
    run(mk(0, 3, 'h21), 0, 0, "R5", 0);
    run(mk(0, 3, 'h22), 0, 1, "R5", 0);

    // R7 misalignment and reserved size
    run(mk(0, 3, 'h21), 1, 1, "R7", 0);
    run(mk(0, 3, 'h23), 0, 1, "R7", 0);
    run(mk(0, 4, 'h42), 1, 2, "R7", 0);
    run(mk(0, 5, 'h41), 0, 2, "R7", 0);
    run(mk(0, 3, 'h40), 1, 3, "R7", 0);

    // R8 port width limits
    cfg_width4 = 0;
    run(mk(0, 4, 'h10), 1, 1, "R8", 0);
    run(mk(0, 4, 'h13), 1, 0, "R8", 0);
    cfg_width4 = 1;
    run(mk(0, 4, 'h10), 0, 2, "R8", 0);
    run(mk(0, 4, 'h12), 1, 1, "R8", 0);
    cfg_width4 = 3;
    run(mk(0, 4, 'h10), 0, 0, "R8", 0);
    cfg_width4 = 2;

    // R9 undecoded areas
    run(mk(0, 0, 0), 0, 2, "R9", 0);
    run(mk(3, 1, 4), 1, 2, "R9", 0);
    run(mk(7, 2, 8), 0, 0, "R9", 0);
    run(mk(1, 6, 0), 1, 1, "R9", 0);
    run(mk(6, 7, 0), 0, 2, "R9", 0);

    // R10 card split
    cfg_card_en = 1; cfg_wait5 = 2;
    run(mk(0, 5, 'h2000000), 0, 2, "R10", 0);
    run(mk(4, 5, 'h1fffffc), 1, 2, "R10", 0);
    run(mk(0, 4, 'h2000000), 1, 2, "R10", 0);
    cfg_card_en = 0;
    run(mk(0, 5, 'h2000000), 0, 2, "R10", 0);

    // R11 back-to-back requests held across the ready cycle
    cfg_wait3 = 0; cfg_wait4 = 3'd1;
    run(mk(0, 3, 0), 0, 2, "R11", 1);
    run(mk(0, 4, 4), 1, 2, "R11", 1);
    run(mk(0, 6, 0), 0, 2, "R11", 1);
    run(mk(2, 3, 1), 1, 0, "R11", 1);
    run(mk(0, 3, 2), 0, 1, "R11", 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad_n);
    $finish;
  end

endmodule